// File: doc/BRIEF.md
# Configuration Boot Loader

This controller fills a register bank from a nonvolatile word array. Once the supply lockout is released it reads the array from the lowest address upward, one word per cycle. Each word goes into a bank of staging latches. After the last staging write it raises one commit pulse, and that pulse moves every staging latch into its active latch at the same time. A fixed delay later it sends a start event to a downstream sequencing engine.

The host can ask for a fresh download at any time the controller is at rest. This puts the stored configuration back over any live edits. The host can also ask for one page of the array to be erased to all ones. The erase happens only when an enable bit is set. The `busy` output stays high from reset until the first download commits, and again during any later download or erase. The bus interface uses it to refuse host transactions with a not-acknowledge.

Top module: `cfg_boot_loader`

## Requirements
- R1: After reset `busy` is 1, and `commit`, `start_seq`, `stg_we`, `nv_rd_en` and `nv_wr_en` are 0. While `lockout_ok` is 0 no read and no staging write takes place. The first read is issued in the cycle after `lockout_ok` is sampled high.
- R2: A download issues `nv_rd_en` for addresses 0 to WORDS-1 in ascending order, one per cycle. The array returns `nv_rdata` one cycle after the read. In that cycle `stg_we` writes `nv_rdata` to `stg_addr`, which equals the address that was read.
- R3: `commit` is a single-cycle pulse in the cycle after the last staging write. No staging write or read is issued in the commit cycle.
- R4: `busy` is 1 from reset until the commit cycle, including the commit cycle itself. It is also 1 during every later download and every erase. It is 0 from the cycle after a commit until the next download or erase begins.
- R5: `start_seq` is a single-cycle pulse in the DELAY_CYC-th cycle after the commit cycle. DELAY_CYC is CLK_HZ/2000 (0.5 ms) unless `DELAY_OVR` is nonzero, in which case DELAY_CYC is `DELAY_OVR`.
- R6: A reload or erase request is acted on only in the resting state, after `start_seq`. A reload accepted there starts a new download in the next cycle, and that download restores any edited active value. Requests made while `busy` is 1, or during the start delay, are ignored.
- R7: An accepted erase request with `erase_en` = 1 writes all ones, one word per cycle, to the PAGE_WORDS addresses `erase_page`*PAGE_WORDS + 0, 1, 2 and so on up to the end of the page. `busy` is 1 during the erase. The controller then returns to rest.
- R8: An erase request with `erase_en` = 0 causes no `nv_wr_en`, leaves the array unchanged and leaves `busy` at 0.
- R9: If `lockout_ok` falls at any point, `busy` is 1 in the next cycle and any download, delay or erase is abandoned without a commit. A full download starts again when `lockout_ok` returns.
- R10: When reload and an enabled erase are requested in the same resting cycle, the reload wins. The next cycle reads address 0 and no erase write happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lockout_ok | input | 1 | Supply is above the lockout threshold |
| reload_req | input | 1 | Host request for a fresh download |
| erase_req | input | 1 | Host page-erase request |
| erase_en | input | 1 | Erase enable control bit |
| erase_page | input | ADDR_W-PAGE_AW | Page to erase |
| nv_rd_en | output | 1 | Array read strobe |
| nv_wr_en | output | 1 | Array write strobe (erase) |
| nv_addr | output | ADDR_W | Array word address |
| nv_wdata | output | DATA_W | Array write data (all ones) |
| nv_rdata | input | DATA_W | Array read data, one cycle after the read strobe |
| stg_we | output | 1 | Staging latch write strobe |
| stg_addr | output | ADDR_W | Staging latch address |
| stg_wdata | output | DATA_W | Staging latch data |
| commit | output | 1 | Copy all staging latches to active latches |
| busy | output | 1 | Host transactions must be refused |
| start_seq | output | 1 | Load the first state into the sequencing engine |

## Verification
The bench goes after the single off-by-one in the read pipeline. A controller that commits one cycle early would drop the last word, and one that writes staging at the read address without the latency would store stale data. It checks a reload made during a download and a reload made during the start delay. A design that accepted either one would restart the transfer and show an early `busy` or a second commit. It also checks an erase with the enable bit low, a reload and an erase in the same cycle, and a lockout drop in the middle of a download. A wrong design would corrupt the array, erase the wrong page, or issue a commit after power was lost.

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 6,
  parameter int PAGE_AW   = 3,
  parameter int CLK_HZ    = 250_000_000,
  parameter int DELAY_OVR = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lockout_ok,
  input  logic                        reload_req,
  input  logic                        erase_req,
  input  logic                        erase_en,
  input  logic [ADDR_W-PAGE_AW-1:0]   erase_page,
  output logic                        nv_rd_en,
  output logic                        nv_wr_en,
  output logic [ADDR_W-1:0]           nv_addr,
  output logic [DATA_W-1:0]           nv_wdata,
  input  logic [DATA_W-1:0]           nv_rdata,
  output logic                        stg_we,
  output logic [ADDR_W-1:0]           stg_addr,
  output logic [DATA_W-1:0]           stg_wdata,
  output logic                        commit,
  output logic                        busy,
  output logic                        start_seq
);
  localparam int WORDS     = 1 << ADDR_W;
  localparam int PAGE_SELW = ADDR_W - PAGE_AW;
  localparam int DELAY_CYC = (DELAY_OVR != 0) ? DELAY_OVR : CLK_HZ / 2000;
  localparam int DLY_W     = $clog2(DELAY_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_COMMIT, S_DELAY, S_DONE, S_ERASE} st_t;
  st_t st;

  logic [ADDR_W:0]        rd_ptr;
  logic                   vld;
  logic [ADDR_W-1:0]      wr_addr;
  logic [DLY_W-1:0]       dly;
  logic [PAGE_SELW-1:0]   pg;
  logic [PAGE_AW-1:0]     eidx;

  wire rd_more = rd_ptr < (ADDR_W+1)'(WORDS);

  assign nv_rd_en  = (st == S_LOAD) && rd_more;
  assign nv_wr_en  = (st == S_ERASE);
  assign nv_addr   = (st == S_ERASE) ? {pg, eidx} : rd_ptr[ADDR_W-1:0];
  assign nv_wdata  = '1;
  assign stg_we    = vld;
  assign stg_addr  = wr_addr;
  assign stg_wdata = nv_rdata;
  assign commit    = (st == S_COMMIT);
  assign busy      = (st == S_IDLE) || (st == S_LOAD) || (st == S_COMMIT) || (st == S_ERASE);
  assign start_seq = (st == S_DELAY) && (dly == DLY_W'(DELAY_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      rd_ptr  <= '0;
      vld     <= 1'b0;
      wr_addr <= '0;
      dly     <= '0;
      pg      <= '0;
      eidx    <= '0;
    end else begin
      vld     <= nv_rd_en && lockout_ok;
      wr_addr <= rd_ptr[ADDR_W-1:0];
      if (!lockout_ok) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: begin
            st     <= S_LOAD;
            rd_ptr <= '0;
          end
          S_LOAD: begin
            if (rd_more)  rd_ptr <= rd_ptr + 1'b1;
            else if (vld) st     <= S_COMMIT;
          end
          S_COMMIT: begin
            st  <= S_DELAY;
            dly <= '0;
          end
          S_DELAY: begin
            if (start_seq) st  <= S_DONE;
            else           dly <= dly + 1'b1;
          end
          S_DONE: begin
            if (reload_req) begin
              st     <= S_LOAD;
              rd_ptr <= '0;
            end else if (erase_req && erase_en) begin
              st   <= S_ERASE;
              pg   <= erase_page;
              eidx <= '0;
            end
          end
          S_ERASE: begin
            if (&eidx) st   <= S_DONE;
            else       eidx <= eidx + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module cfg_boot_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic lockout_ok,
  input logic erase_en,
  input logic busy,
  input logic commit,
  input logic start_seq,
  input logic stg_we,
  input logic nv_rd_en,
  input logic nv_wr_en
);
  a_r2_quiet_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (!stg_we && !nv_rd_en));
  a_r3_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!commit && !busy));
  a_r4_busy_loading: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_we || nv_rd_en || nv_wr_en) |-> busy);
  a_r5_start_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    start_seq |-> (!busy && !commit));
  a_r7_erase_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_wr_en && !$past(nv_wr_en)) |-> $past(erase_en));
  a_r7_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(nv_rd_en && nv_wr_en));
  a_r9_lockout_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !lockout_ok |=> (busy && !commit && !start_seq));
endmodule

bind cfg_boot_loader cfg_boot_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lockout_ok(lockout_ok), .erase_en(erase_en),
  .busy(busy), .commit(commit), .start_seq(start_seq), .stg_we(stg_we),
  .nv_rd_en(nv_rd_en), .nv_wr_en(nv_wr_en)
);

// File: tb/cfg_boot_loader_test.sv
`timescale 1ns/1ps
module cfg_boot_loader_test;
  localparam int DW = 8, AW = 4, PAW = 2, D = 5;
  localparam int W = 1 << AW, P = 1 << PAW;

  logic clk = 0, rst_n = 0, lockout_ok = 0, reload_req = 0, erase_req = 0, erase_en = 0;
  logic [AW-PAW-1:0] erase_page = '0;
  logic nv_rd_en, nv_wr_en, stg_we, commit, busy, start_seq;
  logic [AW-1:0] nv_addr, stg_addr;
  logic [DW-1:0] nv_wdata, nv_rdata = '0, stg_wdata;

  cfg_boot_loader #(.DATA_W(DW), .ADDR_W(AW), .PAGE_AW(PAW), .DELAY_OVR(D)) uut (
    .clk(clk), .rst_n(rst_n), .lockout_ok(lockout_ok), .reload_req(reload_req),
    .erase_req(erase_req), .erase_en(erase_en), .erase_page(erase_page),
    .nv_rd_en(nv_rd_en), .nv_wr_en(nv_wr_en), .nv_addr(nv_addr), .nv_wdata(nv_wdata),
    .nv_rdata(nv_rdata), .stg_we(stg_we), .stg_addr(stg_addr), .stg_wdata(stg_wdata),
    .commit(commit), .busy(busy), .start_seq(start_seq));

  always #2 clk = ~clk;

  logic [DW-1:0] nv_mem [W];
  logic [DW-1:0] stg [W];
  logic [DW-1:0] act [W];
  logic [DW-1:0] snap [W];
  int checks = 0, fails = 0, commits = 0;
  int m_phase = 0, m_cnt = 0, m_page = 0;

  task automatic chk(input bit ok, input string tag, input longint actv, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actv, expv);
    end
  endtask

  always @(posedge clk) begin
    if (nv_rd_en) nv_rdata <= nv_mem[nv_addr];
    if (nv_wr_en) nv_mem[nv_addr] <= nv_wdata;
    if (stg_we) stg[stg_addr] <= stg_wdata;
    if (commit) begin
      for (int i = 0; i < W; i++) act[i] <= stg[i];
      commits <= commits + 1;
    end
  end

  // behavioural reference: 0 idle, 1 load, 2 commit, 3 delay, 4 rest, 5 erase
  always @(posedge clk) begin
    if (!rst_n) begin m_phase <= 0; m_cnt <= 0; end
    else if (!lockout_ok) m_phase <= 0;
    else case (m_phase)
      0: begin m_phase <= 1; m_cnt <= 0; end
      1: if (m_cnt == W) m_phase <= 2; else m_cnt <= m_cnt + 1;
      2: begin m_phase <= 3; m_cnt <= 0; end
      3: if (m_cnt == D - 1) m_phase <= 4; else m_cnt <= m_cnt + 1;
      4: if (reload_req) begin m_phase <= 1; m_cnt <= 0; end
         else if (erase_req && erase_en) begin m_phase <= 5; m_cnt <= 0; m_page <= int'(erase_page); end
      5: if (m_cnt == P - 1) m_phase <= 4; else m_cnt <= m_cnt + 1;
      default: m_phase <= 0;
    endcase
  end

  always @(negedge clk) if (rst_n) begin
    bit eb, ew, er;
    eb = (m_phase == 0) || (m_phase == 1) || (m_phase == 2) || (m_phase == 5);
    ew = (m_phase == 1) && (m_cnt >= 1);
    er = (m_phase == 1) && (m_cnt < W);
    chk(busy == eb, "R4 busy", busy, eb);
    chk(commit == (m_phase == 2), "R3 commit", commit, m_phase == 2);
    chk(start_seq == (m_phase == 3 && m_cnt == D - 1), "R5 start_seq", start_seq, m_phase == 3 && m_cnt == D - 1);
    chk(nv_rd_en == er, "R2 read strobe", nv_rd_en, er);
    chk(stg_we == ew, "R2 staging strobe", stg_we, ew);
    chk(nv_wr_en == (m_phase == 5), "R7 erase strobe", nv_wr_en, m_phase == 5);
    if (er) chk(nv_addr == AW'(m_cnt), "R2 read addr", nv_addr, m_cnt);
    if (ew && stg_we) begin
      chk(stg_addr == AW'(m_cnt - 1), "R2 staging addr", stg_addr, m_cnt - 1);
      chk(stg_wdata == nv_mem[m_cnt - 1], "R2 staging data", stg_wdata, nv_mem[m_cnt - 1]);
    end
    if (m_phase == 5 && nv_wr_en) begin
      chk(nv_addr == AW'(m_page * P + m_cnt), "R7 erase addr", nv_addr, m_page * P + m_cnt);
      chk(nv_wdata == '1, "R7 erase data", nv_wdata, 255);
    end
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_reload; reload_req = 1; cyc(1); reload_req = 0; endtask
  task automatic wait_rest;
    for (int g = 0; g < 500 && m_phase != 4; g++) cyc(1);
  endtask
  task automatic check_active(input string tag);
    for (int i = 0; i < W; i++) chk(act[i] == nv_mem[i], tag, act[i], nv_mem[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < W; i++) begin nv_mem[i] = DW'(i * 7 + 3); stg[i] = '0; act[i] = '0; end
    cyc(3);
    rst_n = 1;
    for (int k = 0; k < 5; k++) begin
      cyc(1);
      chk(busy == 1, "R1 busy after reset", busy, 1);
      chk(!stg_we && !nv_rd_en && !commit && !start_seq && !nv_wr_en, "R1 quiet under lockout", 1, 0);
    end
    lockout_ok = 1;
    cyc(1);
    chk(nv_rd_en == 1 && nv_addr == 0, "R1 first read", nv_rd_en, 1);
    cyc(2);
    pulse_reload;                       // R6: ignored mid-download
    wait_rest;
    chk(commits == 1, "R3 one commit per boot", commits, 1);
    check_active("R2 active matches array");

    act[3] = ~act[3];
    pulse_reload;
    wait_rest;
    chk(act[3] == nv_mem[3], "R6 reload restores edit", act[3], nv_mem[3]);

    pulse_reload;
    for (int g = 0; g < 200 && m_phase != 3; g++) cyc(1);
    cyc(1);
    pulse_reload;                       // R6: ignored during delay
    chk(busy == 0, "R6 reload during delay ignored", busy, 0);
    wait_rest;

    for (int i = 0; i < W; i++) snap[i] = nv_mem[i];
    erase_en = 1; erase_page = 2; erase_req = 1; cyc(1); erase_req = 0;
    wait_rest;
    for (int i = 0; i < W; i++)
      chk(nv_mem[i] == ((i / P == 2) ? 8'hFF : snap[i]), "R7 page erased", nv_mem[i], (i / P == 2) ? 255 : snap[i]);

    for (int i = 0; i < W; i++) snap[i] = nv_mem[i];
    erase_en = 0; erase_page = 1; erase_req = 1; cyc(1); erase_req = 0;
    for (int k = 0; k < 4; k++) begin
      chk(nv_wr_en == 0 && busy == 0, "R8 disabled erase ignored", nv_wr_en, 0);
      cyc(1);
    end
    for (int i = 0; i < W; i++) chk(nv_mem[i] == snap[i], "R8 array unchanged", nv_mem[i], snap[i]);

    pulse_reload;
    wait_rest;
    chk(act[9] == 8'hFF, "R7 erased word reloaded", act[9], 255);

    erase_en = 1; erase_page = 0; erase_req = 1; reload_req = 1; cyc(1);
    erase_req = 0; reload_req = 0;
    chk(nv_rd_en == 1 && nv_wr_en == 0, "R10 reload wins", nv_wr_en, 0);
    wait_rest;
    chk(nv_mem[0] == 8'd3, "R10 no erase", nv_mem[0], 3);

    erase_page = 3; pulse_reload; cyc(2);
    erase_req = 1; cyc(1); erase_req = 0;      // R6: erase while busy ignored
    wait_rest;
    chk(nv_mem[12] == DW'(12 * 7 + 3), "R6 erase while busy ignored", nv_mem[12], 12 * 7 + 3);

    pulse_reload; cyc(4);
    begin
      int c0;
      c0 = commits;
      lockout_ok = 0; cyc(1);
      chk(busy == 1, "R9 busy on lockout", busy, 1);
      cyc(3);
      chk(!stg_we && !nv_rd_en, "R9 download abandoned", stg_we, 0);
      chk(commits == c0, "R9 no commit after lockout", commits, c0);
    end
    lockout_ok = 1;
    wait_rest;
    check_active("R9 full reload after lockout");

    cyc(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule